// File: doc/BRIEF.md
# Dual-Order Burst Word Address Sequencer

This block produces the word address for each beat of a four-beat burst on a synchronous memory. A cycle with the advance control low captures a new start address from outside. Each later cycle with the advance control high moves to the next beat. Only the two lowest address bits take part in the burst. The bits above them stay at the captured value for the whole burst.

An order-select input chooses how the two low bits move:

- **Linear order** counts up from the start offset and wraps modulo four.
- **Interleaved order** XORs the start offset with a beat count of 0, 1, 2, 3.

A suspend input that is active high freezes all state for as long as it is asserted. While it is high, every other input is ignored.

The address output is registered. It shows the decision made at the most recent rising clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the output becomes all zeros, and the internal beat count is cleared as well.
- R2: A load takes place at a rising edge where `susp` is low and `adv_step` is low. After that edge, `word_addr` equals the `start_addr` sampled at the edge, and the beat count restarts at 0.
- R3: An advance takes place at a rising edge where `susp` is low, `adv_step` is high and `ord_sel` is low (linear). After that edge, `word_addr[1:0]` equals (start offset + beats since load) mod 4.
- R4: An advance with `ord_sel` high (interleaved) gives `word_addr[1:0]` equal to the start offset XOR (beats since load mod 4). For example, start offset 01 gives 01, 00, 11, 10. The order applied is the `ord_sel` value sampled at that same edge.
- R5: During advances, `word_addr[ADDR_W-1:2]` stays equal to the upper bits of the last loaded start address.
- R6: After four advances with no load in between, the low offset returns to the start offset, and the sequence repeats.
- R7: At a rising edge where `susp` is high, `adv_step`, `ord_sel` and `start_addr` are ignored, and both the output and the beat count keep their values. The next advance continues from the beat reached before the suspend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| susp | input | 1 | Suspend; when high, all state holds and other inputs are ignored |
| adv_step | input | 1 | 0 loads `start_addr`, 1 advances to the next beat |
| ord_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | External start address, captured on a load |
| word_addr | output | ADDR_W | Registered current word address |

## Verification
The hardest situation to reach is a suspend that lands in the middle of a burst, combined with a change of burst order between beats. The next address must then follow from the beat count saved before the suspend and from the order sampled on the new edge. Random stimulus reaches this case often: it mixes suspends, loads and order flips with fixed weights, so long advance runs are broken up by suspends and order changes. A bench model tracks the loaded base and the beat count and predicts each edge. Directed runs from start offsets 01 and 11 cover both orders through a full wrap.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } op_e;
endpackage

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  bsq_pkg::op_e      op,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else if (op == bsq_pkg::OP_LOAD) base <= start_addr;
  end

  // R5: the captured base changes only on a load
  a_r5_base_hold: assert property (@(posedge clk) disable iff (rst)
    (op != bsq_pkg::OP_LOAD) |=> $stable(base));
  // R2: a load captures the start address
  a_r2_base_load: assert property (@(posedge clk) disable iff (rst)
    (op == bsq_pkg::OP_LOAD) |=> (base == $past(start_addr)));
endmodule

// File: rtl/bsq_step_ctr.sv
module bsq_step_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  bsq_pkg::op_e     op,
  output logic [OFS_W-1:0] step,
  output logic [OFS_W-1:0] step_nxt
);
  always_comb begin
    unique case (op)
      bsq_pkg::OP_LOAD: step_nxt = '0;
      bsq_pkg::OP_STEP: step_nxt = step + 1'b1;
      default:          step_nxt = step;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= step_nxt;
  end

  // R6: each advance moves the beat count by one, modulo the burst length
  a_r6_step_inc: assert property (@(posedge clk) disable iff (rst)
    (op == bsq_pkg::OP_STEP) |=> (step == $past(step) + 1'b1));
  // R7: suspend holds the beat count
  a_r7_step_hold: assert property (@(posedge clk) disable iff (rst)
    (op == bsq_pkg::OP_HOLD) |=> $stable(step));
endmodule

// File: rtl/bsq_offset_gen.sv
module bsq_offset_gen #(
  parameter int OFS_W = 2
) (
  input  logic             [OFS_W-1:0] start_ofs,
  input  logic             [OFS_W-1:0] beat,
  input  bsq_pkg::order_e              order,
  output logic             [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  assign lin_ofs = start_ofs + beat;

  for (genvar b = 0; b < OFS_W; b++) begin : g_xor
    assign ilv_ofs[b] = start_ofs[b] ^ beat[b];
  end

  assign ofs = (order == bsq_pkg::ORD_INTERLEAVE) ? ilv_ofs : lin_ofs;

  // R4: beat zero always maps to the start offset in both orders
  always_comb begin
    if (beat == '0) a_r4_beat0: assert (ofs == start_ofs);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              susp,
  input  logic              adv_step,
  input  logic              ord_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UP_W = ADDR_W - OFS_W;

  bsq_pkg::op_e    op;
  bsq_pkg::order_e order;
  logic [ADDR_W-1:0] base;
  logic [OFS_W-1:0]  step;
  logic [OFS_W-1:0]  step_nxt;
  logic [OFS_W-1:0]  ofs;

  always_comb begin
    if (susp)           op = bsq_pkg::OP_HOLD;
    else if (!adv_step) op = bsq_pkg::OP_LOAD;
    else                op = bsq_pkg::OP_STEP;
  end

  assign order = bsq_pkg::order_e'(ord_sel);

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst(rst), .op(op), .start_addr(start_addr), .base(base)
  );

  bsq_step_ctr #(.OFS_W(OFS_W)) u_step (
    .clk(clk), .rst(rst), .op(op), .step(step), .step_nxt(step_nxt)
  );

  bsq_offset_gen #(.OFS_W(OFS_W)) u_ofs (
    .start_ofs(base[OFS_W-1:0]), .beat(step_nxt), .order(order), .ofs(ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
    end else begin
      unique case (op)
        bsq_pkg::OP_LOAD: word_addr <= start_addr;
        bsq_pkg::OP_STEP: word_addr <= {base[ADDR_W-1:OFS_W], ofs};
        default:          word_addr <= word_addr;
      endcase
    end
  end

  // R1: reset drives the output to zero
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (word_addr == '0));
  // R2: a load presents the start address on the next cycle
  a_r2_load_out: assert property (@(posedge clk) disable iff (rst)
    (!susp && !adv_step) |=> (word_addr == $past(start_addr)));
  // R5: upper bits stay fixed while advancing
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!susp && adv_step) |=> (word_addr[ADDR_W-1:OFS_W] == $past(word_addr[ADDR_W-1:OFS_W])));
  // R7: suspend freezes the output
  a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
    susp |=> $stable(word_addr));

  logic unused_up;
  assign unused_up = (UP_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          susp;
  logic          adv_step;
  logic          ord_sel;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] word_addr;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_step;
  logic [AW-1:0] m_exp;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .OFS_W(2)) uut (
    .clk(clk), .rst(rst), .susp(susp), .adv_step(adv_step),
    .ord_sel(ord_sel), .start_addr(start_addr), .word_addr(word_addr)
  );

  function automatic logic [1:0] beat_ofs(input logic [1:0] s, input logic [1:0] n, input logic ilv);
    return ilv ? (s ^ n) : 2'((s + n) & 2'b11);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(input logic s, input logic a, input logic o, input logic [AW-1:0] sa);
    string tag;
    susp = s; adv_step = a; ord_sel = o; start_addr = sa;
    @(posedge clk);
    if (s) tag = "R7";
    else if (!a) begin
      tag = "R2"; m_base = sa; m_step = 2'd0; m_exp = sa;
    end else begin
      tag = o ? "R4" : "R3";
      m_step = m_step + 2'd1;
      m_exp = {m_base[AW-1:2], beat_ofs(m_base[1:0], m_step, o)};
    end
    @(negedge clk);
    check(tag, word_addr, m_exp);
    if (!s && a) check("R5", {word_addr[AW-1:2], 2'b00}, {m_base[AW-1:2], 2'b00});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst = 1'b1; susp = 1'b0; adv_step = 1'b1; ord_sel = 1'b0; start_addr = '1;
    repeat (3) @(negedge clk);
    check("R1", word_addr, '0);
    rst = 1'b0;
    m_base = '0; m_step = 2'd0; m_exp = '0;
    // R1: advancing straight after reset starts from beat count zero
    cyc(1'b0, 1'b1, 1'b0, '1);
    check("R1", word_addr, 20'h00001);

    // R4 directed: start offset 01 interleaved -> 01 00 11 10 01
    cyc(1'b0, 1'b0, 1'b1, 20'hABC01);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 20'h00000);
    check("R6", word_addr, 20'hABC01);

    // R3 directed: start offset 11 linear -> 11 00 01 10 11
    cyc(1'b0, 1'b0, 1'b0, 20'h5A5A7);
    cyc(1'b0, 1'b1, 1'b0, 20'hFFFFF);
    check("R3", word_addr, 20'h5A5A4);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 20'h12345);
    check("R6", word_addr, 20'h5A5A7);

    // R7 directed: suspend mid burst with changing inputs, then resume
    cyc(1'b0, 1'b1, 1'b0, 20'h0);
    for (int i = 0; i < 3; i++) cyc(1'b1, i[0], 1'b1, 20'hC3C3C);
    check("R7", word_addr, 20'h5A5A4);
    cyc(1'b0, 1'b1, 1'b1, 20'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] < 4'd3, r[7:4] > 4'd3, r[8], AW'($urandom));
    end

    // R1: reset in mid burst
    rst = 1'b1;
    @(negedge clk);
    check("R1", word_addr, '0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule